// File: doc/BRIEF.md
# Vector Functional-Unit Issue Controller

This block sits between an instruction front end and a group of five vector functional units: integer ALU, floating-point unit, slide unit, mask unit and load/store unit. It accepts one instruction at a time over a valid/ready handshake and holds it in a single slot. It issues the instruction to the functional unit selected by its opcode class, over a second valid/ready handshake. Each unit has an in-flight counter that is checked against a configured queue depth.

Each counter is bumped in the cycle an instruction is accepted, not when the instruction leaves. For this reason a counter may sit one above the queue depth. An acceptance that causes this overshoot marks the held instruction with an overflow ticket. The ticket records that the instruction is already counted. It is released in the cycle after a completion pulse brings the count back to the depth, and it is never counted a second time.

Some instructions need a scalar result or a memory acknowledgement. After one of these issues, the controller stays in a WAIT state and issues nothing more until a response or an exception arrives.

Top module: `vfu_issue_ctl`

## Requirements
- R1: The target unit is decoded from the 3-bit opcode class: 0 and 1 go to the ALU (unit 0), 2 to the FPU (unit 1), 3 to the slide unit (unit 2), 4 to the mask unit (unit 3), and 5, 6 and 7 to the load/store unit (unit 4). `issueUnit` carries this code.
- R2: `reqReady` is high when the slot is empty, or when the held instruction issues in the same cycle. Otherwise it is low.
- R3: A unit's counter rises by one on each accepted instruction targeting that unit and falls by one on each completion pulse for that unit. When an acceptance and a completion for the same unit fall in the same cycle, the counter is left unchanged.
- R4: An acceptance that takes its unit's count to QUEUE_DEPTH+1 gives the instruction a ticket. `issueTicket` is high while a ticketed instruction is offered and low for any other instruction.
- R5: A ticketed instruction is not offered while its unit's count exceeds QUEUE_DEPTH. It is offered in the cycle after the completion that brings the count back to QUEUE_DEPTH.
- R6: An instruction without a ticket is offered (`issueValid` high) in every IDLE cycle in which it is held.
- R7: Issuing an instruction with `issueWaitResp` high moves the controller to WAIT. No instruction is offered in WAIT.
- R8: In WAIT, `respValid` or `excValid` returns the controller to IDLE at the next edge. A `respValid` in IDLE has no effect.
- R9: After reset the slot is empty, all counters are zero, the state is IDLE, `issueValid` is low and `reqReady` is high.
- R10: `issueOp` and `issueWaitResp` carry the held instruction's fields. They stay stable while `issueValid` is high and `issueReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Incoming instruction valid |
| reqReady | output | 1 | Controller can take an instruction |
| reqOp | input | 3 | Opcode class of incoming instruction |
| reqWaitResp | input | 1 | Instruction needs a scalar or memory response |
| doneIn | input | 5 | Per-unit completion pulses |
| issueValid | output | 1 | Held instruction offered to its unit |
| issueReady | input | 1 | Unit side takes the instruction |
| issueUnit | output | 3 | Target unit code |
| issueOp | output | 3 | Opcode class being issued |
| issueWaitResp | output | 1 | Issued instruction needs a response |
| issueTicket | output | 1 | Issued instruction holds an overflow ticket |
| respValid | input | 1 | Scalar or memory response arrived |
| excValid | input | 1 | Exception signalled for the pending response |

## Verification
A counter that drifts by one shows up at the ports in one of two ways. It can grant a ticket on the wrong acceptance, so `issueTicket` takes the wrong value at the next offer. It can also move a ticketed release by at least one cycle, which appears as `issueValid` rising early or late relative to the completion pulse. A wrong FSM state shows in the first cycle after a response-bearing issue, through `issueValid` and, in the next cycle, through `reqReady`. A wrong slot state breaks `reqReady` in the same cycle.

// File: rtl/issue_ctl_pkg.sv
package issue_ctl_pkg;
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;
  localparam int OP_W      = 3;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_ALU   = 3'd0,
    UNIT_FPU   = 3'd1,
    UNIT_SLIDE = 3'd2,
    UNIT_MASK  = 3'd3,
    UNIT_LSU   = 3'd4
  } unit_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic fire;
  } ctlStrobe_t;

  function automatic logic [UNIT_W-1:0] decodeUnit(input logic [OP_W-1:0] op);
    unit_e u;
    case (op)
      3'd0, 3'd1: u = UNIT_ALU;
      3'd2:       u = UNIT_FPU;
      3'd3:       u = UNIT_SLIDE;
      3'd4:       u = UNIT_MASK;
      default:    u = UNIT_LSU;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/vfu_issue_dp.sv
module vfu_issue_dp
  import issue_ctl_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [OP_W-1:0]      reqOp,
  input  logic                 reqWaitResp,
  input  logic [NUM_UNITS-1:0] doneIn,
  output logic                 slotValid,
  output logic                 slotRoom,
  output logic [OP_W-1:0]      slotOp,
  output logic [UNIT_W-1:0]    slotUnit,
  output logic                 slotWaitResp,
  output logic                 slotTicket
);
  localparam logic [CNT_W-1:0] DEPTH_C    = CNT_W'(QUEUE_DEPTH);
  localparam logic [CNT_W-1:0] OVERSHOOT_C = CNT_W'(QUEUE_DEPTH + 1);

  logic [CNT_W-1:0]  cntQ [NUM_UNITS];
  logic [CNT_W-1:0]  cntD [NUM_UNITS];
  logic [UNIT_W-1:0] reqUnit;

  assign reqUnit = decodeUnit(reqOp);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cnt
    logic incU;
    logic decU;
    assign incU = strobe.accept && (reqUnit == UNIT_W'(u));
    // a completion with nothing in flight is dropped
    assign decU = doneIn[u] && ((cntQ[u] != '0) || incU);
    assign cntD[u] = cntQ[u] + CNT_W'(incU) - CNT_W'(decU);

    always_ff @(posedge clk) begin
      if (!rstN) cntQ[u] <= '0;
      else       cntQ[u] <= cntD[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid    <= 1'b0;
      slotOp       <= '0;
      slotUnit     <= '0;
      slotWaitResp <= 1'b0;
      slotTicket   <= 1'b0;
    end else if (strobe.accept) begin
      slotValid    <= 1'b1;
      slotOp       <= reqOp;
      slotUnit     <= reqUnit;
      slotWaitResp <= reqWaitResp;
      slotTicket   <= (cntD[reqUnit] == OVERSHOOT_C);
    end else if (strobe.fire) begin
      slotValid    <= 1'b0;
      slotTicket   <= 1'b0;
    end
  end

  // the held instruction is already counted, so room means count <= depth
  assign slotRoom = (cntQ[slotUnit] <= DEPTH_C);
endmodule

// File: rtl/vfu_issue_fsm.sv
module vfu_issue_fsm
  import issue_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       issueReady,
  output logic       issueValid,
  input  logic       respValid,
  input  logic       excValid,
  input  logic       slotValid,
  input  logic       slotRoom,
  input  logic       slotWaitResp,
  output ctlStrobe_t strobe
);
  ctlState_e stateQ, stateD;

  assign issueValid    = slotValid && (stateQ == ST_IDLE) && slotRoom;
  assign strobe.fire   = issueValid && issueReady;
  assign reqReady      = !slotValid || strobe.fire;
  assign strobe.accept = reqValid && reqReady;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strobe.fire && slotWaitResp) stateD = ST_WAIT;
      ST_WAIT: if (respValid || excValid)        stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/vfu_issue_ctl.sv
module vfu_issue_ctl
  import issue_ctl_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [OP_W-1:0]      reqOp,
  input  logic                 reqWaitResp,
  input  logic [NUM_UNITS-1:0] doneIn,
  output logic                 issueValid,
  input  logic                 issueReady,
  output logic [UNIT_W-1:0]    issueUnit,
  output logic [OP_W-1:0]      issueOp,
  output logic                 issueWaitResp,
  output logic                 issueTicket,
  input  logic                 respValid,
  input  logic                 excValid
);
  ctlStrobe_t strobe;
  logic       slotValid;
  logic       slotRoom;

  vfu_issue_dp #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqOp        (reqOp),
    .reqWaitResp  (reqWaitResp),
    .doneIn       (doneIn),
    .slotValid    (slotValid),
    .slotRoom     (slotRoom),
    .slotOp       (issueOp),
    .slotUnit     (issueUnit),
    .slotWaitResp (issueWaitResp),
    .slotTicket   (issueTicket)
  );

  vfu_issue_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .issueReady   (issueReady),
    .issueValid   (issueValid),
    .respValid    (respValid),
    .excValid     (excValid),
    .slotValid    (slotValid),
    .slotRoom     (slotRoom),
    .slotWaitResp (issueWaitResp),
    .strobe       (strobe)
  );
endmodule

// File: rtl/vfu_issue_ctl_chk.sv
module vfu_issue_ctl_chk
  import issue_ctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [OP_W-1:0]   reqOp,
  input logic              issueValid,
  input logic              issueReady,
  input logic [UNIT_W-1:0] issueUnit,
  input logic [OP_W-1:0]   issueOp,
  input logic              issueWaitResp,
  input logic              issueTicket,
  input logic              respValid,
  input logic              excValid
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady |=> issueValid && $stable(issueOp) && $stable(issueWaitResp));

  p_busy_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady |-> !reqReady);

  p_wait_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueReady && issueWaitResp |=> !issueValid);

  p_reset_state_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !issueValid && reqReady);

  p_unit_decode_r1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> issueUnit == decodeUnit(issueOp));

  p_take_fresh_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> $stable(issueOp) || issueOp == $past(reqOp));
endmodule

bind vfu_issue_ctl vfu_issue_ctl_chk u_chk (.*);

// File: tb/vfu_issue_ctl_bench.sv
`timescale 1ns/1ps
module vfu_issue_ctl_bench;
  localparam int DEPTH = 4;
  localparam int NU    = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqReady, reqWaitResp = 1'b0;
  logic [2:0] reqOp = '0;
  logic [4:0] doneIn = '0;
  logic       issueValid, issueReady = 1'b0, issueWaitResp, issueTicket;
  logic [2:0] issueUnit, issueOp;
  logic       respValid = 1'b0, excValid = 1'b0;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int   mCnt [NU];
  bit   mSlotV, mSlotResp, mSlotTicket, mWait, mLeftWait;
  logic [2:0] mSlotOp;

  always #2 clk = ~clk;

  vfu_issue_ctl #(.QUEUE_DEPTH(DEPTH)) u_vfu_issue_ctl (.*);

  function automatic int unitOf(input logic [2:0] op);
    if (op <= 3'd1) return 0;
    if (op == 3'd2) return 1;
    if (op == 3'd3) return 2;
    if (op == 3'd4) return 3;
    return 4;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of stimulus, port checks, and model update
  task automatic step(input bit v, input logic [2:0] op, input bit wr,
                      input bit rdy, input logic [4:0] dn, input bit rs, input bit ex);
    bit expIV, expFire, expRR, acc;
    int nCnt [NU];
    @(negedge clk);
    reqValid = v; reqOp = op; reqWaitResp = wr; issueReady = rdy;
    doneIn = dn; respValid = rs; excValid = ex;
    #1;
    expIV   = mSlotV && !mWait && (mCnt[unitOf(mSlotOp)] <= DEPTH);
    expFire = expIV && rdy;
    expRR   = !mSlotV || expFire;
    check("R2 reqReady", reqReady, expRR);
    if (mSlotTicket)    check("R5 issueValid", issueValid, expIV);
    else if (mWait)     check("R7 issueValid", issueValid, expIV);
    else if (mLeftWait) check("R8 issueValid", issueValid, expIV);
    else                check("R6 issueValid", issueValid, expIV);
    if (expIV) begin
      check("R1 issueUnit", issueUnit, unitOf(mSlotOp));
      check("R10 issueOp", issueOp, mSlotOp);
      check("R10 issueWaitResp", issueWaitResp, mSlotResp);
      check("R4 issueTicket", issueTicket, mSlotTicket);
    end
    acc = v && expRR;
    for (int u = 0; u < NU; u++) begin
      bit inc = acc && (unitOf(op) == u);
      bit dec = dn[u] && (mCnt[u] != 0 || inc);
      nCnt[u] = mCnt[u] + int'(inc) - int'(dec);
    end
    mLeftWait = 1'b0;
    if (!mWait && expFire && mSlotResp) mWait = 1'b1;
    else if (mWait && (rs || ex)) begin mWait = 1'b0; mLeftWait = 1'b1; end
    if (acc) begin
      mSlotV = 1'b1; mSlotOp = op; mSlotResp = wr;
      mSlotTicket = (nCnt[unitOf(op)] == DEPTH + 1);
    end else if (expFire) begin
      mSlotV = 1'b0; mSlotTicket = 1'b0;
    end
    for (int u = 0; u < NU; u++) mCnt[u] = nCnt[u];
    @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int u = 0; u < NU; u++) mCnt[u] = 0;
    mSlotV = 0; mSlotResp = 0; mSlotTicket = 0; mWait = 0; mLeftWait = 0; mSlotOp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset reqReady", reqReady, 1);
    check("R9 reset issueValid", issueValid, 0);
    rstN = 1'b1;
    @(posedge clk);

    // fill the ALU queue: four issue freely
    for (int i = 0; i < 4; i++) step(1, 3'd0, 0, 1, 5'b0, 0, 0);
    // fifth overshoots and takes a ticket
    step(1, 3'd1, 0, 1, 5'b0, 0, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    check("R5 ticket held", issueValid, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    // completion returns count to depth
    step(0, 3'd0, 0, 0, 5'b00001, 0, 0);
    #1;
    check("R5 ticket released", issueValid, 1);
    check("R4 ticket flag", issueTicket, 1);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    // same-cycle arrival and completion on the ALU at depth: no ticket
    step(1, 3'd0, 0, 0, 5'b00001, 0, 0);
    #1;
    check("R3 same-cycle no ticket", issueTicket, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    // response-bearing FPU op, stray response in IDLE first
    step(1, 3'd2, 1, 0, 5'b0, 1, 0);
    step(1, 3'd3, 0, 1, 5'b0, 0, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    step(0, 3'd0, 0, 1, 5'b0, 1, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);
    // exception path out of WAIT
    step(1, 3'd6, 1, 1, 5'b0, 0, 0);
    step(1, 3'd4, 0, 1, 5'b0, 0, 0);
    step(0, 3'd0, 0, 1, 5'b0, 0, 1);
    step(0, 3'd0, 0, 1, 5'b0, 0, 0);

    // constrained random phase
    void'($urandom(32'd1337));
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] dn = '0;
      for (int u = 0; u < NU; u++)
        if (mCnt[u] > 0 && ($urandom % 5) == 0) dn[u] = 1'b1;
      step(($urandom % 4) != 0, 3'($urandom), ($urandom % 6) == 0,
           ($urandom % 4) != 0, dn, mWait && ($urandom % 3) == 0,
           ($urandom % 17) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule